// File: doc/BRIEF.md
# Programmable Interrupt Priority Controller

This block collects eight level-sensitive interrupt request lines and presents one interrupt output to a processor. Each line can be masked on its own. The block keeps a record of which lines are currently being serviced, and it decides which pending request should be offered next. When the processor answers with a two-pulse acknowledge sequence, the block picks the winning line on the first pulse. On the second pulse it places an 8-bit vector on its data output.

Software configures the block through a write port that takes four kinds of command word: an initialisation word, a mode word, a mask word and a control word. In the default fully nested scheme, line 0 has the highest priority and a line in service holds off itself and every line below it. The other schemes are:

- **Special mask mode.** A masked in-service line stops holding off other lines.
- **Special fully nested mode.** Intended for a cascade master, this mode lets the in-service line interrupt again.
- **Automatic end of service.** The in-service bit is dropped without a command.
- **Buffered mode.** An external bus-buffer enable follows the block's data drive.

A read port returns the in-service, mask, raw request and configuration state, so a handler can test whether anything is still in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, or after a write with selector 0, the in-service and mask registers and every mode flag are zero and `irq_out` is low. A selector-0 write also loads the vector base from `wr_data[7:3]`.
- R2: `irq_in` is sampled every clock. `irq_out` reflects a sampled request one clock later. Line 0 has the highest fixed priority and line 7 the lowest.
- R3: On the second acknowledge pulse, `data_oe` is high exactly while `ack` is high, and `data_out` carries {base[4:0], line[2:0]}. At every other time `data_oe` is low and `data_out` is zero.
- R4: The rising edge of the first acknowledge pulse picks the highest-priority eligible request and sets its in-service bit. The bit can be read one clock later.
- R5: A write with selector 2 loads the mask register. Mask bit n removes line n from consideration and leaves every other line unaffected.
- R6: In the default mode, when the highest-priority in-service bit is at line k, only requests on lines with an index below k raise `irq_out`.
- R7: Mode-word bit 4 selects special fully nested mode. In this mode a request on line k itself, or on any line above it in priority, raises `irq_out` while line k is in service.
- R8: Control-word bit 6 = 1 copies bit 5 into the special-mask flag, and bit 6 = 0 leaves the flag unchanged. While the flag is set, in-service bits of masked lines hold off no other line.
- R9: Control-word bit 0 clears the lowest-index in-service bit that is set. Apart from this, the in-service register changes only on a clock where `ack` differs from its previous sampled value, or on a write.
- R10: Mode-word bit 1 enables automatic end of service. The in-service bit set by the first pulse clears on the clock that samples the fall of the second pulse.
- R11: If no eligible request exists when the first pulse is sampled, the vector is {base, 3'b111} and no in-service bit is set.
- R12: Mode-word bit 3 selects buffered mode, in which `buf_en` equals `data_oe`. Without buffered mode, `buf_en` stays low. Mode-word bit 2 records the master role.
- R13: `rd_sel` selects what `rd_data` returns: 0 gives the in-service register, 1 the mask, 2 the sampled requests, and 3 gives {special-mask, fully-nested, buffered, master, auto-end} in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Level-sensitive request lines, line 0 highest |
| wr_en | input | 1 | Command write strobe |
| wr_sel | input | 2 | Command kind: 0 init, 1 mode, 2 mask, 3 control |
| wr_data | input | 8 | Command word |
| rd_sel | input | 2 | Read selector |
| rd_data | output | 8 | Selected register contents |
| ack | input | 1 | Acknowledge pulses from the processor, active high |
| irq_out | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Vector during the second acknowledge pulse, else zero |
| data_oe | output | 1 | High while the vector is driven |
| buf_en | output | 1 | Bus-buffer enable in buffered mode |

## Verification
The hardest state to reach from the ports is one where special mask mode, a masked in-service line and a fresh request on a lower line all hold together. Such a request has to be granted even though an earlier service routine never ended. The stimulus builds this state in order. It acknowledges line 4 and leaves it in service. It then masks line 4 and enters special mask mode with a control write. Next it sweeps a single request across all eight lines, and finally it acknowledges line 6 and retires both bits with two end-of-service commands. The spurious-acknowledge path is reached in a similar way: a request is raised, withdrawn one clock before the first pulse, and the acknowledge sequence is then run.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned NLINE = 8;
    localparam int unsigned IDXW  = $clog2(NLINE);
    localparam int unsigned VECW  = 8;
    localparam int unsigned BASEW = VECW - IDXW;

    typedef logic [NLINE-1:0] line_vec_t;
    typedef logic [IDXW-1:0]  line_idx_t;
    typedef logic [BASEW-1:0] base_t;

    // command-word selectors
    localparam logic [1:0] SEL_INIT = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    // read selectors
    localparam logic [1:0] RD_ISR = 2'd0;
    localparam logic [1:0] RD_IMR = 2'd1;
    localparam logic [1:0] RD_IRR = 2'd2;
    localparam logic [1:0] RD_CFG = 2'd3;

    // bit positions inside the mode word
    localparam int unsigned MODE_AUTO_BIT   = 1;
    localparam int unsigned MODE_MASTER_BIT = 2;
    localparam int unsigned MODE_BUF_BIT    = 3;
    localparam int unsigned MODE_NEST_BIT   = 4;

    // bit positions inside the control word
    localparam int unsigned CTRL_EOI_BIT    = 0;
    localparam int unsigned CTRL_SMVAL_BIT  = 5;
    localparam int unsigned CTRL_SMEN_BIT   = 6;

    typedef struct packed {
        logic nest;      // special fully nested
        logic buffered;
        logic master;
        logic auto_end;
    } mode_t;

    typedef struct packed {
        logic      hit;
        line_idx_t idx;
    } pick_t;

    typedef enum logic [1:0] {
        AQ_IDLE  = 2'd0,
        AQ_FIRST = 2'd1,
        AQ_GAP   = 2'd2
    } ack_state_e;

    // lowest set index wins (highest priority)
    function automatic pick_t top_line(line_vec_t v);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = NLINE - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = line_idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic line_vec_t line_bit(line_idx_t i);
        return line_vec_t'(1) << i;
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [1:0] wr_sel,
    input  logic [VECW-1:0] wr_data,
    input  line_vec_t irq_in,
    input  logic      set_en,
    input  line_idx_t set_idx,
    input  logic      auto_clr_en,
    input  line_idx_t auto_clr_idx,
    output line_vec_t irr,
    output line_vec_t imr,
    output line_vec_t isr,
    output mode_t     mode,
    output logic      smm,
    output base_t     base
);
    line_vec_t irr_q, imr_q, isr_q, set_mask, clr_mask;
    mode_t     mode_q;
    logic      smm_q;
    base_t     base_q;
    pick_t     eoi_pick;
    logic      w_init, w_mode, w_mask, w_ctrl;

    assign w_init = wr_en && (wr_sel == SEL_INIT);
    assign w_mode = wr_en && (wr_sel == SEL_MODE);
    assign w_mask = wr_en && (wr_sel == SEL_MASK);
    assign w_ctrl = wr_en && (wr_sel == SEL_CTRL);

    always_comb begin
        eoi_pick = top_line(isr_q);
        clr_mask = '0;
        if (w_ctrl && wr_data[CTRL_EOI_BIT] && eoi_pick.hit)
            clr_mask = clr_mask | line_bit(eoi_pick.idx);
        if (auto_clr_en)
            clr_mask = clr_mask | line_bit(auto_clr_idx);
        set_mask = set_en ? line_bit(set_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            imr_q  <= '0;
            isr_q  <= '0;
            mode_q <= '0;
            smm_q  <= 1'b0;
            base_q <= '0;
        end else begin
            irr_q <= irq_in;
            if (w_init) begin
                base_q <= wr_data[VECW-1:IDXW];
                imr_q  <= '0;
                isr_q  <= '0;
                mode_q <= '0;
                smm_q  <= 1'b0;
            end else begin
                isr_q <= (isr_q | set_mask) & ~clr_mask;
                if (w_mode) begin
                    mode_q.auto_end <= wr_data[MODE_AUTO_BIT];
                    mode_q.master   <= wr_data[MODE_MASTER_BIT];
                    mode_q.buffered <= wr_data[MODE_BUF_BIT];
                    mode_q.nest     <= wr_data[MODE_NEST_BIT];
                end
                if (w_mask)
                    imr_q <= wr_data[NLINE-1:0];
                if (w_ctrl && wr_data[CTRL_SMEN_BIT])
                    smm_q <= wr_data[CTRL_SMVAL_BIT];
            end
        end
    end

    assign irr  = irr_q;
    assign imr  = imr_q;
    assign isr  = isr_q;
    assign mode = mode_q;
    assign smm  = smm_q;
    assign base = base_q;
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
    import pic_pkg::*;
(
    input  line_vec_t irr,
    input  line_vec_t imr,
    input  line_vec_t isr,
    input  logic      smm,
    input  logic      nest,
    output logic      grant_ok,
    output pick_t     winner
);
    line_vec_t pending, blockers;
    pick_t     p_pick, b_pick;

    always_comb begin
        pending  = irr & ~imr;
        // in special mask mode a masked in-service line blocks nobody
        blockers = smm ? (isr & ~imr) : isr;
        p_pick   = top_line(pending);
        b_pick   = top_line(blockers);
        if (!p_pick.hit)
            grant_ok = 1'b0;
        else if (!b_pick.hit)
            grant_ok = 1'b1;
        else if (nest)
            grant_ok = (p_pick.idx <= b_pick.idx);
        else
            grant_ok = (p_pick.idx < b_pick.idx);
        winner = p_pick;
    end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_clr,
    input  logic      ack,
    input  logic      grant_ok,
    input  pick_t     winner,
    input  logic      auto_end,
    input  base_t     base,
    output logic      set_en,
    output line_idx_t set_idx,
    output logic      clr_en,
    output line_idx_t clr_idx,
    output logic      drive,
    output logic [VECW-1:0] vec
);
    ack_state_e state_q;
    logic       ack_q, rise, fall;
    pick_t      held_q;

    assign rise = ack && !ack_q;
    assign fall = !ack && ack_q;

    assign set_en  = (state_q == AQ_IDLE) && rise && grant_ok;
    assign set_idx = winner.idx;
    assign clr_en  = (state_q == AQ_GAP) && fall && auto_end && held_q.hit;
    assign clr_idx = held_q.idx;
    assign drive   = (state_q == AQ_GAP) && ack;
    assign vec     = {base, held_q.hit ? held_q.idx : {IDXW{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            state_q <= AQ_IDLE;
            held_q  <= '0;
        end else begin
            ack_q <= ack;
            if (init_clr) begin
                state_q <= AQ_IDLE;
                held_q  <= '0;
            end else begin
                unique case (state_q)
                    AQ_IDLE: if (rise) begin
                        held_q.hit <= grant_ok;
                        held_q.idx <= winner.idx;
                        state_q    <= AQ_FIRST;
                    end
                    AQ_FIRST: if (fall) state_q <= AQ_GAP;
                    AQ_GAP:   if (fall) state_q <= AQ_IDLE;
                    default:  state_q <= AQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    input  logic       ack,
    output logic       irq_out,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       buf_en
);
    line_vec_t irr_w, imr_w, isr_w;
    mode_t     mode_w;
    logic      smm_w, grant_w, set_en_w, clr_en_w;
    line_idx_t set_idx_w, clr_idx_w;
    base_t     base_w;
    pick_t     win_w;
    logic [VECW-1:0] vec_w;

    pic_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_in(irq_in), .set_en(set_en_w), .set_idx(set_idx_w),
        .auto_clr_en(clr_en_w), .auto_clr_idx(clr_idx_w),
        .irr(irr_w), .imr(imr_w), .isr(isr_w), .mode(mode_w), .smm(smm_w), .base(base_w)
    );

    pic_resolve u_res (
        .irr(irr_w), .imr(imr_w), .isr(isr_w), .smm(smm_w), .nest(mode_w.nest),
        .grant_ok(grant_w), .winner(win_w)
    );

    pic_ack_seq u_seq (
        .clk(clk), .rst(rst), .init_clr(wr_en && (wr_sel == SEL_INIT)), .ack(ack),
        .grant_ok(grant_w), .winner(win_w), .auto_end(mode_w.auto_end), .base(base_w),
        .set_en(set_en_w), .set_idx(set_idx_w), .clr_en(clr_en_w), .clr_idx(clr_idx_w),
        .drive(data_oe), .vec(vec_w)
    );

    assign irq_out  = grant_w;
    assign data_out = data_oe ? vec_w : '0;
    assign buf_en   = data_oe && mode_w.buffered;

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            RD_ISR:  rd_data = isr_w;
            RD_IMR:  rd_data = imr_w;
            RD_IRR:  rd_data = irr_w;
            default: rd_data[4:0] = {smm_w, mode_w};
        endcase
    end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
    import pic_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      ack,
    input logic      wr_en,
    input line_vec_t isr,
    input line_vec_t imr,
    input line_vec_t irr,
    input logic      buffered,
    input logic      data_oe,
    input logic      buf_en,
    input logic      irq_out
);
    logic ack_prev;
    always_ff @(posedge clk) begin
        if (rst) ack_prev <= 1'b0;
        else     ack_prev <= ack;
    end

    // R9
    isr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (ack == ack_prev)) |=> $stable(isr));

    // R4
    isr_single_set_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(isr & ~$past(isr)) <= 1);

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~imr) == '0) |-> !irq_out);

    // R3
    drive_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ack);

    // R12
    buf_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !buffered |-> !buf_en);
endmodule

bind prio_irq_ctrl pic_chk u_chk (
    .clk(clk), .rst(rst), .ack(ack), .wr_en(wr_en),
    .isr(isr_w), .imr(imr_w), .irr(irr_w), .buffered(mode_w.buffered),
    .data_oe(data_oe), .buf_en(buf_en), .irq_out(irq_out)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, ack = 1'b0;
    logic [7:0] irq = '0, wr_data = '0;
    logic [1:0] wr_sel = '0, rd_sel = '0;
    logic [7:0] rd_data, data_out;
    logic irq_out, data_oe, buf_en;

    always #10 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_in(irq), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ack(ack),
        .irq_out(irq_out), .data_out(data_out), .data_oe(data_oe), .buf_en(buf_en)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_isr = '0, m_imr = '0;
    logic [4:0] m_base = '0;
    logic m_smm = 0, m_nest = 0, m_auto = 0, m_buf = 0, m_master = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int first_idx(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic exp_irq();
        int p, b;
        p = first_idx(irq & ~m_imr);
        b = first_idx(m_smm ? (m_isr & ~m_imr) : m_isr);
        if (p == 8) return 1'b0;
        if (b == 8) return 1'b1;
        return m_nest ? (p <= b) : (p < b);
    endfunction

    function automatic logic [7:0] cfg_val();
        return {3'b000, m_smm, m_nest, m_buf, m_master, m_auto};
    endfunction

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        int e;
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0;
        case (s)
            2'd0: begin m_base = d[7:3]; m_imr = '0; m_isr = '0; m_smm = 0;
                        m_nest = 0; m_buf = 0; m_master = 0; m_auto = 0; end
            2'd1: begin m_auto = d[1]; m_master = d[2]; m_buf = d[3]; m_nest = d[4]; end
            2'd2: m_imr = d;
            default: begin
                if (d[0]) begin
                    e = first_idx(m_isr);
                    if (e < 8) m_isr[e] = 1'b0;
                end
                if (d[6]) m_smm = d[5];
            end
        endcase
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq = v;
        step();
    endtask

    // full two-pulse acknowledge with checks on the bus timing
    task automatic do_ack();
        int p;
        logic ok;
        logic [7:0] ev, v;
        ok = exp_irq();
        p  = first_idx(irq & ~m_imr);
        ev = {m_base, ok ? p[2:0] : 3'd7};
        ack = 1'b1;
        #1 chk("R3 no drive in first pulse", data_oe, 0);
        step();
        if (ok) m_isr[p] = 1'b1;
        rd(2'd0, v);
        chk(ok ? "R4 in-service set" : "R11 nothing set", v, m_isr);
        ack = 1'b0;
        step();
        ack = 1'b1;
        #1;
        chk(ok ? "R3 vector" : "R11 default vector", data_out, ev);
        chk("R3 drive in second pulse", data_oe, 1);
        chk("R12 buffer enable", buf_en, m_buf);
        step();
        ack = 1'b0;
        #1;
        chk("R3 drive released", data_oe, 0);
        chk("R3 bus zero", data_out, 0);
        chk("R12 buffer released", buf_en, 0);
        step();
        if (ok && m_auto) m_isr[p] = 1'b0;
        rd(2'd0, v);
        chk("R10 in-service after sequence", v, m_isr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 irq_out after reset", irq_out, 0);
        chk("R1 no drive after reset", data_oe, 0);
        chk("R1 buf_en after reset", buf_en, 0);
        rd(2'd0, v); chk("R1 isr after reset", v, 0);
        rd(2'd1, v); chk("R1 imr after reset", v, 0);
        rd(2'd3, v); chk("R1 cfg after reset", v, 0);

        wr(2'd0, 8'hA8);
        // R2 R4 R6 R9: every request pattern
        for (int pat = 1; pat < 256; pat++) begin
            set_irq(pat[7:0]);
            chk("R2 irq_out for pattern", irq_out, exp_irq());
            rd(2'd2, v); chk("R13 sampled requests", v, pat[7:0]);
            do_ack();
            chk("R6 winner holds off the rest", irq_out, exp_irq());
            wr(2'd3, 8'h01);
            rd(2'd0, v); chk("R9 end of service", v, m_isr);
            set_irq(8'h00);
        end

        // R5 every mask with all lines requesting
        set_irq(8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr(2'd2, m[7:0]);
            chk("R5 irq_out under mask", irq_out, exp_irq());
            rd(2'd1, v); chk("R13 mask readback", v, m[7:0]);
            if (m != 255) begin
                do_ack();
                wr(2'd3, 8'h01);
            end
        end
        wr(2'd2, 8'h00);
        set_irq(8'h00);

        // R6 / R7: line 4 in service
        set_irq(8'h10);
        do_ack();
        for (int j = 0; j < 8; j++) begin
            set_irq(8'(1 << j));
            chk("R6 nested hold-off", irq_out, (j < 4));
        end
        wr(2'd1, 8'h10);
        rd(2'd3, v); chk("R13 cfg nested", v, cfg_val());
        for (int j = 0; j < 8; j++) begin
            set_irq(8'(1 << j));
            chk("R7 fully nested re-entry", irq_out, (j <= 4));
        end
        wr(2'd1, 8'h00);

        // R8 special mask mode with masked in-service line 4
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h60);
        rd(2'd3, v); chk("R8 special mask entered", v, cfg_val());
        for (int j = 0; j < 8; j++) begin
            set_irq(8'(1 << j));
            chk("R8 masked in-service ignored", irq_out, (j != 4));
        end
        wr(2'd3, 8'h20);
        rd(2'd3, v); chk("R8 flag kept without enable", v[4], 1);
        wr(2'd2, 8'h00);
        for (int j = 0; j < 8; j++) begin
            set_irq(8'(1 << j));
            chk("R8 unmasked in-service blocks", irq_out, (j < 4));
        end
        wr(2'd2, 8'h10);
        set_irq(8'h40);
        do_ack();
        rd(2'd0, v); chk("R8 lower line granted", v, 8'h50);
        wr(2'd3, 8'h01);
        rd(2'd0, v); chk("R9 highest in-service cleared first", v, 8'h40);
        wr(2'd3, 8'h01);
        rd(2'd0, v); chk("R9 second clear", v, 8'h00);
        wr(2'd3, 8'h40);
        rd(2'd3, v); chk("R8 special mask left", v[4], 0);
        set_irq(8'h00);

        // R10 automatic end of service on every line
        wr(2'd0, 8'h40);
        rd(2'd1, v); chk("R1 init clears mask", v, 0);
        wr(2'd1, 8'h02);
        for (int k = 0; k < 8; k++) begin
            set_irq(8'(1 << k));
            do_ack();
            set_irq(8'h00);
        end

        // R11 request withdrawn before first pulse
        set_irq(8'h08);
        chk("R11 request seen", irq_out, 1);
        set_irq(8'h00);
        do_ack();
        // R11 only masked requests present
        wr(2'd2, 8'h20);
        set_irq(8'h20);
        do_ack();
        wr(2'd2, 8'h00);
        set_irq(8'h00);

        // R12 buffered master
        wr(2'd1, 8'h0C);
        rd(2'd3, v); chk("R13 cfg buffered master", v, cfg_val());
        set_irq(8'h04);
        chk("R12 idle buffer", buf_en, 0);
        do_ack();
        wr(2'd3, 8'h01);
        set_irq(8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule